// File: doc/BRIEF.md
# Four-Bit Dual-Table ALU Slice

This block is a purely combinational ALU slice. Two 4-bit operands, a 4-bit function code and a mode bit select one of thirty-two operations. With the mode bit low, the code picks an arithmetic operation. Each arithmetic operation adds two operands chosen from A and B, plus the carry-in. With the mode bit high, the same code picks a bitwise logic function from a second table. In logic mode the carry-in plays no part.

Besides the result, the slice gives a carry-out and an all-ones flag. The all-ones flag works as an equality detector when the subtract-style code runs with a zero carry-in. It also exports the group propagate and group generate of its internal addition, so that several slices can be chained through an external lookahead unit. The slice has no clock and no state. All pins are plain combinational signals with no handshake, so back-pressure does not apply.

Top module: `alu_slice4`

## Requirements
- R1: With mode=0, the result is (X + Y + cin) mod 16 for these codes. Code 0000 uses X=A, Y=1111, giving A−1+cin. Code 0110 uses X=A, Y=~B, giving A−B−1+cin. Code 1001 uses X=A, Y=B. Code 1011 uses X=A|B, Y=0. Code 1100 uses X=A, Y=A.
- R2: With mode=0, the other codes also compute (X + Y + cin) mod 16, with these operands. 0001: X=A, Y=A&B. 0010: X=A, Y=A&~B. 0011: X=A, Y=0. 0100: X=A, Y=A|B. 0101: X=A, Y=A|~B. 0111: X=A, Y=A^B. 1000: X=A, Y=~A&B. 1010: X=A, Y=~(A^B). 1101: X=A&B, Y=0. 1110: X=A, Y=~A. 1111: X=B, Y=0.
- R3: With mode=1, the result is a bitwise function of A and B selected by the code, as follows. 0000 gives ~A. 0001 gives A&B. 0010 gives A|B. 0011 gives ~(A&B). 0100 gives ~(A|B). 0101 gives A. 0110 gives A^B. 0111 gives B. 1000 gives ~B. 1001 gives ~(A^B). 1010 gives 0000. 1011 gives 1111. 1100 gives A&~B. 1101 gives ~A&B. 1110 gives A|~B. 1111 gives ~A|B.
- R4: With mode=0, cout is bit 4 of X + Y + cin.
- R5: With mode=1, cout is 0.
- R6: aeqb is 1 exactly when the result is 1111, in both modes. With mode=0, code 0110 and cin=0, aeqb is therefore 1 exactly when A equals B.
- R7: With mode=0, grp_p is 1 exactly when every bit position has X|Y set.
- R8: With mode=0, grp_g is 1 exactly when X + Y (without cin) overflows 4 bits.
- R9: With mode=1, grp_p and grp_g are both 0.
- R10: With mode=1, changing cin changes none of the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | Operand A |
| b_in | input | 4 | Operand B |
| fsel | input | 4 | Function code |
| mode | input | 1 | 0 selects the arithmetic table, 1 the logic table |
| cin | input | 1 | Carry-in (arithmetic mode only) |
| f_out | output | 4 | Result |
| cout | output | 1 | Carry-out |
| aeqb | output | 1 | Result is all ones |
| grp_p | output | 1 | Group propagate |
| grp_g | output | 1 | Group generate |

## Verification
Immediate assertions are evaluated whenever the inputs change. They check that the lookahead sum matches a wide addition of the selected operands, that the carry-out agrees with the group propagate/generate terms and the carry-in, and that logic mode forces carry, propagate and generate to zero. They also check that the subtract code with a zero carry-in flags equality, and that logic code 0110 gives the exclusive OR. The operand-selection tables themselves cannot be checked that way. The assertions also cannot show that the carry-in has no effect in logic mode. Only the bench shows these, through its exhaustive sweep against a separate reference and its paired carry-in comparisons.

// File: rtl/alu_slice_pkg.sv
`timescale 1ns/1ps
package alu_slice_pkg;
  localparam int SEL_W = 4;
  typedef logic [SEL_W-1:0] sel_t;

  // Codes whose behaviour a neighbouring block or an assertion relies on
  localparam sel_t OPC_DEC    = 4'b0000;
  localparam sel_t OPC_SUB    = 4'b0110;
  localparam sel_t OPC_ADD    = 4'b1001;
  localparam sel_t OPC_ORPASS = 4'b1011;
  localparam sel_t OPC_DOUBLE = 4'b1100;
endpackage

// File: rtl/alu_opsel.sv
`timescale 1ns/1ps
// Chooses the two addends for the arithmetic table.
module alu_opsel
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  sel_t             code,
  output logic [WIDTH-1:0] x,
  output logic [WIDTH-1:0] y
);
  localparam logic [WIDTH-1:0] ONES  = '1;
  localparam logic [WIDTH-1:0] ZEROS = '0;

  always_comb begin
    x = a;
    y = ZEROS;
    unique case (code)
      4'b0000: y = ONES;            // R1
      4'b0001: y = a & b;           // R2
      4'b0010: y = a & ~b;
      4'b0011: y = ZEROS;
      4'b0100: y = a | b;
      4'b0101: y = a | ~b;
      4'b0110: y = ~b;              // R1
      4'b0111: y = a ^ b;
      4'b1000: y = ~a & b;
      4'b1001: y = b;               // R1
      4'b1010: y = ~(a ^ b);
      4'b1011: x = a | b;           // R1
      4'b1100: y = a;               // R1
      4'b1101: x = a & b;
      4'b1110: y = ~a;
      4'b1111: x = b;
      default: y = ZEROS;
    endcase
  end
endmodule

// File: rtl/alu_cla.sv
`timescale 1ns/1ps
// Flattened carry-lookahead adder with group propagate/generate.
module alu_cla #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             gp,
  output logic             gg
);
  logic [WIDTH-1:0] prop, gen, half;
  logic [WIDTH:0]   carry;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign prop[gi] = x[gi] | y[gi];
      assign gen[gi]  = x[gi] & y[gi];
      assign half[gi] = x[gi] ^ y[gi];
      assign sum[gi]  = half[gi] ^ carry[gi];
    end
  endgenerate

  // Each carry is a two-level sum of products over the lower positions.
  always_comb begin
    carry[0] = cin;
    for (int i = 0; i < WIDTH; i++) begin
      logic acc;
      logic chain;
      acc   = 1'b0;
      chain = 1'b1;
      for (int j = i; j >= 0; j--) begin
        acc   = acc | (gen[j] & chain);
        chain = chain & prop[j];
      end
      carry[i+1] = acc | (chain & cin);
    end
  end

  always_comb begin
    logic chain;
    gg    = 1'b0;
    chain = 1'b1;
    for (int j = WIDTH - 1; j >= 0; j--) begin
      gg    = gg | (gen[j] & chain);
      chain = chain & prop[j];
    end
    gp = &prop;
  end

  assign cout = carry[WIDTH];

  always_comb begin
    AST_SUM_MATCHES_WIDE_ADD: assert ({cout, sum} ==
      ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin})); // R4
    AST_CARRY_FROM_GROUP: assert (cout == (gg | (gp & cin))); // R8
  end
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise function table used when the mode bit is high.
module alu_logic
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  sel_t             code,
  output logic [WIDTH-1:0] f
);
  always_comb begin
    unique case (code)
      4'b0000: f = ~a;
      4'b0001: f = a & b;
      4'b0010: f = a | b;
      4'b0011: f = ~(a & b);
      4'b0100: f = ~(a | b);
      4'b0101: f = a;
      4'b0110: f = a ^ b;
      4'b0111: f = b;
      4'b1000: f = ~b;
      4'b1001: f = ~(a ^ b);
      4'b1010: f = '0;
      4'b1011: f = '1;
      4'b1100: f = a & ~b;
      4'b1101: f = ~a & b;
      4'b1110: f = a | ~b;
      4'b1111: f = ~a | b;
      default: f = '0;
    endcase
  end

  always_comb begin
    if (code == 4'b0110)
      AST_LOGIC_XOR_CODE: assert (f == (a ^ b)); // R3
  end
endmodule

// File: rtl/alu_slice4.sv
`timescale 1ns/1ps
module alu_slice4
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [SEL_W-1:0] fsel,
  input  logic             mode,
  input  logic             cin,
  output logic [WIDTH-1:0] f_out,
  output logic             cout,
  output logic             aeqb,
  output logic             grp_p,
  output logic             grp_g
);
  logic [WIDTH-1:0] op_x, op_y, arith_f, logic_f;
  logic             add_c, add_p, add_g;

  alu_opsel #(.WIDTH(WIDTH)) u_opsel (
    .a(a_in), .b(b_in), .code(fsel), .x(op_x), .y(op_y)
  );

  alu_cla #(.WIDTH(WIDTH)) u_cla (
    .x(op_x), .y(op_y), .cin(cin),
    .sum(arith_f), .cout(add_c), .gp(add_p), .gg(add_g)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a(a_in), .b(b_in), .code(fsel), .f(logic_f)
  );

  always_comb begin
    if (mode) begin
      f_out = logic_f;
      cout  = 1'b0;
      grp_p = 1'b0;
      grp_g = 1'b0;
    end else begin
      f_out = arith_f;
      cout  = add_c;
      grp_p = add_p;
      grp_g = add_g;
    end
  end

  assign aeqb = &f_out;

  always_comb begin
    if (mode) begin
      AST_LOGIC_NO_CARRY: assert (!cout); // R5
      AST_LOGIC_NO_GROUP: assert (!grp_p && !grp_g); // R9
    end
    if (!mode && fsel == OPC_SUB && !cin)
      AST_SUB_FLAGS_EQUAL: assert (aeqb == (a_in == b_in)); // R6
  end
endmodule

// File: tb/tb_alu_slice4.sv
`timescale 1ns/1ps
module tb_alu_slice4;
  logic       clk = 1'b0;
  logic [3:0] a_in = '0, b_in = '0, fsel = '0;
  logic       mode = 1'b0, cin = 1'b0;
  logic [3:0] f_out;
  logic       cout, aeqb, grp_p, grp_g;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu_slice4 dut (
    .a_in(a_in), .b_in(b_in), .fsel(fsel), .mode(mode), .cin(cin),
    .f_out(f_out), .cout(cout), .aeqb(aeqb), .grp_p(grp_p), .grp_g(grp_g)
  );

  typedef struct packed {
    logic [3:0] f;
    logic       c;
    logic       eq;
    logic       p;
    logic       g;
  } exp_t;

  // Reference model built from the requirement text.
  function automatic exp_t model(input logic m, input logic [3:0] s,
                                 input logic [3:0] a, input logic [3:0] b,
                                 input logic ci);
    exp_t r;
    logic [3:0] x, y;
    logic [4:0] full, noci;
    r = '0;
    if (m) begin
      case (s)
        4'd0:  r.f = ~a;          4'd1:  r.f = a & b;
        4'd2:  r.f = a | b;       4'd3:  r.f = ~(a & b);
        4'd4:  r.f = ~(a | b);    4'd5:  r.f = a;
        4'd6:  r.f = a ^ b;       4'd7:  r.f = b;
        4'd8:  r.f = ~b;          4'd9:  r.f = ~(a ^ b);
        4'd10: r.f = 4'h0;        4'd11: r.f = 4'hF;
        4'd12: r.f = a & ~b;      4'd13: r.f = ~a & b;
        4'd14: r.f = a | ~b;      default: r.f = ~a | b;
      endcase
    end else begin
      x = a; y = 4'h0;
      case (s)
        4'd0:  y = 4'hF;          4'd1:  y = a & b;
        4'd2:  y = a & ~b;        4'd3:  y = 4'h0;
        4'd4:  y = a | b;         4'd5:  y = a | ~b;
        4'd6:  y = ~b;            4'd7:  y = a ^ b;
        4'd8:  y = ~a & b;        4'd9:  y = b;
        4'd10: y = ~(a ^ b);      4'd11: x = a | b;
        4'd12: y = a;             4'd13: x = a & b;
        4'd14: y = ~a;            default: x = b;
      endcase
      full = {1'b0, x} + {1'b0, y} + {4'b0, ci};
      noci = {1'b0, x} + {1'b0, y};
      r.f = full[3:0];
      r.c = full[4];
      r.p = &(x | y);
      r.g = noci[4];
    end
    r.eq = (r.f == 4'hF);
    return r;
  endfunction

  task automatic drive(input logic m, input logic [3:0] s, input logic [3:0] a,
                       input logic [3:0] b, input logic ci);
    @(posedge clk);
    mode = m; fsel = s; a_in = a; b_in = b; cin = ci;
    @(negedge clk);
  endtask

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (m=%b s=%b a=%h b=%h cin=%b)",
               tag, act, exp, mode, fsel, a_in, b_in, cin);
    end
  endtask

  // {mode, code, a, b, cin, f, cout, aeqb}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 4'b0000, 4'h0, 4'h0, 1'b0, 4'hF, 1'b0, 1'b1}, // idle inputs, R1
    {1'b0, 4'b0000, 4'h5, 4'h0, 1'b1, 4'h5, 1'b1, 1'b0}, // R1 decrement, cin cancels
    {1'b0, 4'b0110, 4'h7, 4'h7, 1'b0, 4'hF, 1'b0, 1'b1}, // R6 equal operands
    {1'b0, 4'b0110, 4'h9, 4'h3, 1'b1, 4'h6, 1'b1, 1'b0}, // R1 true subtract
    {1'b0, 4'b1001, 4'hF, 4'h1, 1'b0, 4'h0, 1'b1, 1'b0}, // R4 wrap to zero
    {1'b0, 4'b1100, 4'h8, 4'h0, 1'b1, 4'h1, 1'b1, 1'b0}, // R1 doubling
    {1'b0, 4'b1011, 4'h4, 4'h2, 1'b1, 4'h7, 1'b0, 1'b0}, // R1 or-then-increment
    {1'b0, 4'b1110, 4'h6, 4'h0, 1'b0, 4'hF, 1'b0, 1'b1}, // R2 A plus ~A
    {1'b1, 4'b0000, 4'hA, 4'h0, 1'b0, 4'h5, 1'b0, 1'b0}, // R3 invert A
    {1'b1, 4'b0110, 4'hC, 4'hA, 1'b0, 4'h6, 1'b0, 1'b0}, // R3 xor
    {1'b1, 4'b1001, 4'hC, 4'hA, 1'b1, 4'h9, 1'b0, 1'b0}, // R5 xnor, no carry
    {1'b1, 4'b1011, 4'h3, 4'h9, 1'b1, 4'hF, 1'b0, 1'b1}  // R6 all ones in logic mode
  };

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    exp_t e;
    exp_t e0;
    // Directed vectors
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:7], VEC[i][6]);
      cmp($sformatf("directed vec %0d R1/R2/R3 result", i), {4'h0, f_out}, {4'h0, VEC[i][5:2]});
      cmp($sformatf("directed vec %0d R4/R5 cout", i), {7'h0, cout}, {7'h0, VEC[i][1]});
      cmp($sformatf("directed vec %0d R6 aeqb", i), {7'h0, aeqb}, {7'h0, VEC[i][0]});
    end

    // R7 all positions propagate, no generate
    drive(1'b0, 4'b1001, 4'hA, 4'h5, 1'b0);
    cmp("R7 grp_p on complementary add", {7'h0, grp_p}, 8'h1);
    cmp("R8 grp_g clear without overflow", {7'h0, grp_g}, 8'h0);
    // R8 generate on overflow; carry then independent of cin
    drive(1'b0, 4'b1001, 4'h8, 4'h8, 1'b0);
    cmp("R8 grp_g on overflow", {7'h0, grp_g}, 8'h1);
    cmp("R7 grp_p partial", {7'h0, grp_p}, 8'h0);
    // R9 logic mode forces group outputs low even where arithmetic would not
    drive(1'b1, 4'b1001, 4'hF, 4'hF, 1'b1);
    cmp("R9 grp_p/grp_g in logic mode", {6'h0, grp_p, grp_g}, 8'h0);

    // R10 carry-in has no effect in logic mode, every code
    for (int s = 0; s < 16; s++) begin
      logic [3:0] f0;
      logic [3:0] o0;
      drive(1'b1, s[3:0], 4'h6, 4'h3, 1'b0);
      f0 = f_out;
      o0 = {cout, aeqb, grp_p, grp_g};
      drive(1'b1, s[3:0], 4'h6, 4'h3, 1'b1);
      cmp($sformatf("R10 code %0d cin ignored", s), {f_out, cout, aeqb, grp_p, grp_g}, {f0, o0});
    end

    // Exhaustive sweep against the reference
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int c = 0; c < 2; c++) begin
              drive(m[0], s[3:0], a[3:0], b[3:0], c[0]);
              e = model(m[0], s[3:0], a[3:0], b[3:0], c[0]);
              e0 = {f_out, cout, aeqb, grp_p, grp_g};
              if (e0 !== e) begin
                if (f_out !== e.f)
                  cmp(m ? "R3 logic result" :
                      ((s == 0 || s == 6 || s == 9 || s == 11 || s == 12) ?
                       "R1 arith result" : "R2 arith result"), {4'h0, f_out}, {4'h0, e.f});
                else if (cout !== e.c)
                  cmp(m ? "R5 cout" : "R4 cout", {7'h0, cout}, {7'h0, e.c});
                else if (aeqb !== e.eq)
                  cmp("R6 aeqb", {7'h0, aeqb}, {7'h0, e.eq});
                else if (grp_p !== e.p)
                  cmp(m ? "R9 grp_p" : "R7 grp_p", {7'h0, grp_p}, {7'h0, e.p});
                else
                  cmp(m ? "R9 grp_g" : "R8 grp_g", {7'h0, grp_g}, {7'h0, e.g});
              end else begin
                checks++;
              end
            end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule